// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer Bank

This block holds a set of independent 32-bit down-counters behind one simple register bus. Each channel is reloaded from a programmable start value and counts down by one per clock while it runs. When it passes zero it reloads, adds one to its own wrap counter and raises a sticky event flag. A channel runs only while both a shared master enable and its own enable are set. The event flag can drive a per-channel interrupt line through a mask bit.

The live count is not read directly. Reading a channel's wrap-count register returns the wrap count and, in the same access, copies the live count into a snapshot register. Software then reads the snapshot, so the pair it gets was taken at the same instant. With an all-ones start value, the bitwise inverse of the snapshot is the number of ticks since the channel started. The bus has one cycle per access: the read data is combinational from the address, and a write takes effect at the clock edge on which it is presented.

Top module: `cdt_block`

## Requirements
- R1: After reset every register reads zero, except the start value and the snapshot, which read 0xFFFFFFFF, and the revision word at byte offset 0x10, which reads the REV parameter. Offsets that map to no register read zero. Writes to the revision, snapshot, wrap-count and event-flag registers have no effect.
- R2: A channel counts only while bit 0 of the master control word (offset 0x00) and bit 0 of its own enable register are both 1. Otherwise its live count holds its value.
- R3: On the first clock on which a channel runs after not running, the live count loads the start value.
- R4: A running channel decrements by one per clock. The clock after it reaches zero, it reloads the start value and its wrap count (offset +0x0C) increases by one.
- R5: Bit 0 of the event-flag register (+0x10) is set on every reload from zero. Writing 1 to bit 0 of the clear register (+0x14) clears it, writing 0 leaves it unchanged, and a set on the same clock wins over a clear.
- R6: A channel's interrupt output is 1 exactly when both its event flag and bit 0 of its mask register (+0x18) are 1. A mask of 0 keeps the output low.
- R7: A read of the wrap-count register copies the live count into the snapshot register (+0x08). The snapshot changes at no other time, so a later read of the snapshot returns the value captured by the most recent wrap-count read.
- R8: Channel n occupies the 32-byte window starting at 0x20 + 0x20*n, with enable at +0x00 and start value at +0x04. Accesses to one channel never change another.
- R9: With a start value of 0xFFFFFFFF, the bitwise inverse of a captured snapshot equals the number of decrements since the channel started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe; data is stored on this clock edge |
| bus_rd | input | 1 | Read strobe; needed for the capture side effect |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Combinational read data for bus_addr |
| irq | output | NCH | Per-channel interrupt lines |

## Verification
A channel enabled on clock edge E loads its start value at edge E+1. After that, the live count after edge E+1+j is the start value minus (j mod (start+1)), and the wrap count is j/(start+1). The bench counts the edges spent by each bus task: an enable write, N idle clocks and then a wrap-count read put the capture N+1 edges after E, so the expected snapshot uses j = N-1. Read data is sampled one nanosecond after the strobe is driven, before the edge that stores the capture. Interrupt and flag changes are checked one nanosecond after the write edge that causes them.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

   // Register kinds inside one channel window
   typedef enum logic [2:0] {
      K_NONE   = 3'd0,
      K_CFG    = 3'd1,
      K_RELOAD = 3'd2,
      K_VALUE  = 3'd3,
      K_OVF    = 3'd4,
      K_STAT   = 3'd5,
      K_CLR    = 3'd6,
      K_MASK   = 3'd7
   } chreg_e;

   localparam int unsigned OFF_CTRL  = 'h00;
   localparam int unsigned OFF_REV   = 'h10;
   localparam int unsigned WIN_SHIFT = 5;   // 32-byte windows

   function automatic chreg_e kind_of(input logic [4:0] off);
      chreg_e k;
      case (off)
         5'h00:   k = K_CFG;
         5'h04:   k = K_RELOAD;
         5'h08:   k = K_VALUE;
         5'h0C:   k = K_OVF;
         5'h10:   k = K_STAT;
         5'h14:   k = K_CLR;
         5'h18:   k = K_MASK;
         default: k = K_NONE;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/cdt_decode.sv
module cdt_decode
   import cdt_pkg::*;
#(
   parameter int ADDR_W = 8,
   localparam int WIN_W = ADDR_W - WIN_SHIFT
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit_ctrl,
   output logic              hit_rev,
   output logic [WIN_W-1:0]  win,
   output chreg_e            kind
);

   always_comb begin
      win      = addr[ADDR_W-1:WIN_SHIFT];
      hit_ctrl = (addr == ADDR_W'(OFF_CTRL));
      hit_rev  = (addr == ADDR_W'(OFF_REV));
      if (win == '0) begin
         kind = K_NONE;
      end else begin
         kind = kind_of(addr[4:0]);
      end
   end

endmodule

// File: rtl/cdt_channel.sv
module cdt_channel #(
   parameter int DW      = 32,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          g_en,
   input  logic          wr_cfg,
   input  logic          wr_reload,
   input  logic          wr_clr,
   input  logic          wr_mask,
   input  logic          cap,
   input  logic [DW-1:0] wdata,
   output logic          cfg_en,
   output logic [DW-1:0] reload,
   output logic [DW-1:0] shadow,
   output logic [DW-1:0] ovf,
   output logic          status,
   output logic          mask,
   output logic          irq
);

   localparam logic [DW-1:0] ONES = '1;

   logic          run;
   logic          run_d;
   logic [DW-1:0] cnt;
   logic          wrap;

   assign run  = g_en & cfg_en;
   assign wrap = run & run_d & (cnt == '0);

   // Configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_en <= 1'b0;
         reload <= ONES;
         mask   <= 1'b0;
      end else begin
         if (wr_cfg)    cfg_en <= wdata[0];
         if (wr_reload) reload <= wdata;
         if (wr_mask)   mask   <= wdata[0];
      end
   end

   // Live counter and wrap count
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_d <= 1'b0;
         cnt   <= ONES;
         ovf   <= '0;
      end else begin
         run_d <= run;
         if (run) begin
            if (!run_d) begin
               cnt <= reload;
            end else if (cnt == '0) begin
               cnt <= reload;
               ovf <= ovf + 1'b1;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

   // Snapshot taken on a wrap-count read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   shadow <= ONES;
      else if (cap) shadow <= cnt;
   end

   // Sticky event flag, set beats clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  status <= 1'b0;
      else if (wrap)               status <= 1'b1;
      else if (wr_clr && wdata[0]) status <= 1'b0;
   end

   generate
      if (IRQ_REG) begin : g_irq_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= status & mask;
         end
      end else begin : g_irq_comb
         assign irq = status & mask;
      end
   endgenerate

   // Checks next to the counter
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(cnt));
   assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !run_d) |=> (cnt == $past(reload)));
   assert_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && run_d && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
   assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && run_d && cnt == '0) |=> (cnt == $past(reload) && ovf == $past(ovf) + 1'b1));
   assert_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && run_d && cnt == '0) |=> status);
   assert_snap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> (shadow == $past(cnt)));
   assert_snap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> $stable(shadow));

endmodule

// File: rtl/cdt_block.sv
module cdt_block
   import cdt_pkg::*;
#(
   parameter int          NCH     = 4,
   parameter int          DW      = 32,
   parameter int          ADDR_W  = 8,
   parameter logic [31:0] REV     = 32'h0001_0002,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic [NCH-1:0]    irq
);

   localparam int WIN_W = ADDR_W - WIN_SHIFT;

   // Elaboration-time parameter checks
   generate
      if (NCH < 1) begin : g_bad_nch
         $error("cdt_block: NCH must be at least 1");
      end
      if (DW < 8 || DW > 32) begin : g_bad_dw
         $error("cdt_block: DW must lie in 8..32");
      end
      if (ADDR_W < 6 || ((NCH + 1) << WIN_SHIFT) > (1 << ADDR_W)) begin : g_bad_aw
         $error("cdt_block: ADDR_W too small for NCH windows");
      end
   endgenerate

   logic             hit_ctrl;
   logic             hit_rev;
   logic [WIN_W-1:0] win;
   chreg_e           kind;
   logic             g_en;
   logic [DW-1:0]    ch_rd [NCH];
   logic [NCH-1:0]   ch_sel;

   cdt_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr     (bus_addr),
      .hit_ctrl (hit_ctrl),
      .hit_rev  (hit_rev),
      .win      (win),
      .kind     (kind)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  g_en <= 1'b0;
      else if (bus_wr && hit_ctrl) g_en <= bus_wdata[0];
   end

   generate
      for (genvar n = 0; n < NCH; n++) begin : g_ch
         logic          c_en;
         logic [DW-1:0] c_reload;
         logic [DW-1:0] c_shadow;
         logic [DW-1:0] c_ovf;
         logic          c_status;
         logic          c_mask;
         logic          wr_here;

         assign ch_sel[n] = (win == WIN_W'(n + 1));
         assign wr_here   = bus_wr & ch_sel[n];

         cdt_channel #(.DW(DW), .IRQ_REG(IRQ_REG)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .g_en      (g_en),
            .wr_cfg    (wr_here && kind == K_CFG),
            .wr_reload (wr_here && kind == K_RELOAD),
            .wr_clr    (wr_here && kind == K_CLR),
            .wr_mask   (wr_here && kind == K_MASK),
            .cap       (bus_rd && ch_sel[n] && kind == K_OVF),
            .wdata     (bus_wdata),
            .cfg_en    (c_en),
            .reload    (c_reload),
            .shadow    (c_shadow),
            .ovf       (c_ovf),
            .status    (c_status),
            .mask      (c_mask),
            .irq       (irq[n])
         );

         always_comb begin
            case (kind)
               K_CFG:    ch_rd[n] = DW'(c_en);
               K_RELOAD: ch_rd[n] = c_reload;
               K_VALUE:  ch_rd[n] = c_shadow;
               K_OVF:    ch_rd[n] = c_ovf;
               K_STAT:   ch_rd[n] = DW'(c_status);
               K_MASK:   ch_rd[n] = DW'(c_mask);
               default:  ch_rd[n] = '0;
            endcase
         end

         if (!IRQ_REG) begin : g_irq_chk
            assert_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
               irq[n] |-> (c_status && c_mask));
         end
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (hit_ctrl) begin
         bus_rdata = DW'(g_en);
      end else if (hit_rev) begin
         bus_rdata = REV[DW-1:0];
      end else begin
         for (int n = 0; n < NCH; n++) begin
            if (ch_sel[n]) bus_rdata = ch_rd[n];
         end
      end
   end

   assert_onesel_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_sel));

endmodule

// File: tb/sim_cdt_block.sv
module sim_cdt_block;

   localparam logic [31:0] REVV = 32'h0001_0002;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   cdt_block #(.REV(REVV)) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   function automatic logic [7:0] ca(input int ch, input int off);
      return 8'(32'h20 + 32'h20 * ch + off);
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      #1 bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(posedge clk);
      #1 bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      bus_read(8'h00, v);      chk("R1 ctrl", v, 0);
      bus_read(8'h10, v);      chk("R1 rev", v, REVV);
      bus_read(ca(0, 4), v);   chk("R1 reload", v, 32'hFFFF_FFFF);
      bus_read(ca(0, 8), v);   chk("R1 value", v, 32'hFFFF_FFFF);
      bus_read(ca(1, 'h0C), v); chk("R1 ovf", v, 0);
      bus_read(ca(2, 'h10), v); chk("R1 status", v, 0);
      bus_read(ca(3, 'h18), v); chk("R1 mask", v, 0);
      bus_read(ca(3, 0), v);   chk("R1 cfg", v, 0);
      bus_read(8'h04, v);      chk("R1 unmapped 04", v, 0);
      bus_read(ca(1, 'h1C), v); chk("R1 unmapped 1C", v, 0);
      bus_read(8'hFC, v);      chk("R1 unmapped FC", v, 0);
      bus_write(8'h10, 32'h1234);
      bus_read(8'h10, v);      chk("R1 rev ro", v, REVV);
      bus_write(ca(2, 'h0C), 32'h55);
      bus_read(ca(2, 'h0C), v); chk("R1 ovf ro", v, 0);
   endtask

   // start 5: period 6 ticks
   task automatic t_count_irq;
      logic [31:0] v, a, b;
      bus_write(ca(0, 4), 5);
      bus_write(8'h00, 1);
      bus_write(ca(0, 0), 1);          // edge E
      idle(9);
      bus_read(ca(0, 'h0C), v);        // j = 8
      chk("R4 wrap count", v, 1);
      bus_read(ca(0, 8), v);   chk("R4 R7 snapshot", v, 3);
      bus_read(ca(0, 'h10), v); chk("R5 flag set", v, 1);
      chk("R6 masked irq", 32'(irq[0]), 0);
      idle(5);
      bus_read(ca(0, 8), v);   chk("R7 snapshot stable", v, 3);
      bus_write(ca(0, 'h18), 1);
      chk("R6 irq on", 32'(irq[0]), 1);
      bus_write(ca(0, 0), 0);          // stop
      bus_write(ca(0, 'h14), 0);
      bus_read(ca(0, 'h10), v); chk("R5 clear 0", v, 1);
      bus_write(ca(0, 'h14), 1);
      bus_read(ca(0, 'h10), v); chk("R5 clear 1", v, 0);
      chk("R6 irq off", 32'(irq[0]), 0);
      bus_read(ca(0, 'h0C), v);
      bus_read(ca(0, 8), a);
      idle(7);
      bus_read(ca(0, 'h0C), v);
      bus_read(ca(0, 8), b);
      chk("R2 local disable holds", b, a);
      bus_write(ca(0, 0), 1);          // edge E
      idle(1);
      bus_read(ca(0, 'h0C), v);        // j = 0
      bus_read(ca(0, 8), v);   chk("R3 restart load", v, 5);
      bus_write(ca(0, 0), 0);
   endtask

   task automatic t_global_gate;
      logic [31:0] v;
      bus_write(8'h00, 0);
      bus_write(ca(1, 4), 3);
      bus_write(ca(1, 0), 1);
      idle(10);
      bus_read(ca(1, 'h0C), v); chk("R2 gated ovf", v, 0);
      bus_read(ca(1, 8), v);   chk("R2 gated count", v, 32'hFFFF_FFFF);
      bus_read(ca(1, 'h10), v); chk("R2 gated flag", v, 0);
      bus_write(ca(1, 0), 0);
   endtask

   task automatic t_elapsed;
      logic [31:0] v;
      bus_write(8'h00, 1);
      bus_write(ca(3, 0), 1);          // edge E
      idle(20);
      bus_read(ca(3, 'h0C), v);        // j = 19
      chk("R9 wraps", v, 0);
      bus_read(ca(3, 8), v);   chk("R9 elapsed", ~v, 19);
      bus_read(ca(2, 'h0C), v); chk("R8 other ovf", v, 0);
      bus_read(ca(2, 8), v);   chk("R8 other count", v, 32'hFFFF_FFFF);
      bus_read(ca(2, 4), v);   chk("R8 other reload", v, 32'hFFFF_FFFF);
      bus_read(ca(0, 4), v);   chk("R8 ch0 reload kept", v, 5);
      chk("R8 R6 no stray irq", 32'(irq), 0);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_count_irq();
      t_global_gate();
      t_elapsed();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule